// File: doc/BRIEF.md
# Dual-Mode Logic Analyzer Capture Core

This block records a 40-channel parallel probe bus into on-chip sample memory. It holds two independent acquisition machines. The timing machine owns the two low pods and takes samples on a programmable divider of the system clock, with no regard to any clock of the circuit under test. The state machine owns the three high pods and takes one sample for each rising edge of an external clock. A qualifier input gates those edges, and a programmable delay in system clocks sets where the sample is taken.

Each machine is armed by a pulse and waits, storing nothing, until a masked pattern on its own channels matches. A cross-trigger setting lets the two machines fire together, or lets one machine's trigger start the other. When a machine's memory is full, it raises its done flag and stops writing. Stored samples are read back by address through a registered read port.

Top module: `la_capture_core`

## Requirements
- R1: Probe bits 15:0 (pods 0 and 1) feed the timing machine, and bits 39:16 (pods 2, 3 and 4) feed the state machine. `pod_en[p]` enables pod p. A disabled pod's channels are stored as zero and take part in matching as zero. A machine with none of its pods enabled does not arm.
- R2: A one-cycle `arm` pulse takes effect at the next clock edge. It puts every enabled machine in the armed state, clears its done flag and resets its write position to entry 0. An armed machine stores nothing before it triggers.
- R3: A machine's own trigger occurs when `(word & mask) == (match & mask)` on its masked channels. The timing machine evaluates this every cycle. The state machine evaluates it only on qualified capture strobes. The triggering word is stored as entry 0.
- R4: After triggering, the timing machine stores one sample every `t_div + 1` system cycles. A divider of 0 stores one sample on every cycle.
- R5: The external clock and qualifier each pass through a two-stage synchroniser. Suppose `ext_clk` rises between system edges and `s_delay` is 0. The state sample is then the probe word present at the third system rising edge after the external rise.
- R6: An external clock rise seen while the synchronised qualifier is low stores nothing and cannot trigger the state machine.
- R7: A nonzero `s_delay` of d moves the state sample point d system cycles later, to the (3+d)-th system edge after the external rise.
- R8: After storing DEPTH entries, a machine sets its done flag, stops writing and stays done until it is armed again.
- R9: `xtrig_mode` selects how triggers interact. 0: each machine starts only on its own trigger. 1: a trigger of either machine starts both. 2: the timing trigger starts the state machine, which ignores its own match. 3: the state trigger starts the timing machine, which ignores its own match. The state machine's first sample after a cross start is the next qualified strobe.
- R10: `rd_data` shows, one cycle after `rd_sel`/`rd_addr` are applied, the stored entry of the state memory (`rd_sel`=1) or of the timing memory zero-extended to 24 bits (`rd_sel`=0). `rd_data` is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe | input | 40 | Five 8-bit probe pods |
| ext_clk | input | 1 | External capture clock for the state machine |
| ext_qual | input | 1 | Qualifier gating external clock edges |
| pod_en | input | 5 | Per-pod enable |
| xtrig_mode | input | 2 | Cross-trigger selection |
| arm | input | 1 | Arm pulse for both machines |
| t_div | input | 16 | Timing sample divider (interval minus one) |
| s_delay | input | 8 | State sample delay in system cycles |
| t_mask | input | 16 | Timing trigger mask |
| t_match | input | 16 | Timing trigger value |
| s_mask | input | 24 | State trigger mask |
| s_match | input | 24 | State trigger value |
| rd_sel | input | 1 | Read memory select, 1 = state |
| rd_addr | input | 10 | Read entry address |
| rd_data | output | 24 | Registered read data |
| t_armed | output | 1 | Timing machine waiting for trigger |
| t_done | output | 1 | Timing memory full |
| s_armed | output | 1 | State machine waiting for trigger |
| s_done | output | 1 | State memory full |

## Verification
The assertions assume that configuration inputs (`pod_en`, `t_div`, `s_delay`, masks, `xtrig_mode`) stay still while a capture is in progress. They also assume that `arm` is a single-cycle pulse. The stimulus changes settings only between captures, while both machines are idle, done or about to be re-armed. The strobe-spacing property relies on the external clock being slower than the system clock, with high and low phases each lasting several system cycles. The bench drives external pulses that stay high for at least five cycles and low for at least four, always longer than the programmed delay.

// File: rtl/la_pkg.sv
package la_pkg;

  typedef enum logic [1:0] {
    XT_INDEP  = 2'd0,
    XT_SHARED = 2'd1,
    XT_T2S    = 2'd2,
    XT_S2T    = 2'd3
  } xtrig_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // May a machine start on its own pattern match under this mode?
  function automatic logic own_start_ok(xtrig_e m, logic is_timing);
    return is_timing ? (m != XT_S2T) : (m != XT_T2S);
  endfunction

  // May a machine start on the other machine's trigger under this mode?
  function automatic logic cross_start_ok(xtrig_e m, logic is_timing);
    return (m == XT_SHARED) || (is_timing ? (m == XT_S2T) : (m == XT_T2S));
  endfunction

endpackage

// File: rtl/la_edge_sync.sv
module la_edge_sync #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             ext_qual,
  input  logic [DLY_W-1:0] delay,
  output logic             strobe
);
  logic [2:0]       ck_sh;
  logic [1:0]       q_sh;
  logic             qedge;
  logic             pend;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sh <= '0;
      q_sh  <= '0;
    end else begin
      ck_sh <= {ck_sh[1:0], ext_clk};
      q_sh  <= {q_sh[0], ext_qual};
    end
  end

  // qualified rising edge of the synchronised external clock
  assign qedge  = ck_sh[1] & ~ck_sh[2] & q_sh[1];
  assign strobe = (qedge && delay == '0) || (pend && cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (qedge && delay != '0) begin
      pend <= 1'b1;
      cnt  <= delay - 1'b1;
    end else if (pend) begin
      if (cnt == '0) pend <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R5: synchronised edges are at least two cycles apart, and so are strobes
  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/la_pacer.sv
module la_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             wr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  function automatic logic [DIV_W-1:0] next_count(logic [DIV_W-1:0] c,
                                                 logic [DIV_W-1:0] d,
                                                 logic reload);
    if (reload)      return d;
    if (c != '0)     return c - 1'b1;
    return c;
  endfunction

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= next_count(cnt, div, wr);
  end

  // R4: with a nonzero divider two stores never fall on consecutive cycles
  assert_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && div != '0) |=> !wr);

endmodule

// File: rtl/la_machine.sv
module la_machine
  import la_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          arm,
  input  logic          sample_ok,
  input  logic          pace_ok,
  input  logic [W-1:0]  word,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  value,
  input  logic          own_allowed,
  input  logic          cross_allowed,
  input  logic          cross_go,
  output logic          own_ev,
  output logic          wr,
  output logic          armed,
  output logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  phase_e        ph;
  logic [AW-1:0] ptr;
  logic          go;
  logic          last;
  logic [W-1:0]  mem [DEPTH];

  function automatic logic pattern_hit(logic [W-1:0] w, logic [W-1:0] m,
                                       logic [W-1:0] v);
    return ((w ^ v) & m) == '0;
  endfunction

  assign own_ev = (ph == PH_ARMED) && sample_ok && pattern_hit(word, mask, value);
  assign go     = !arm && (ph == PH_ARMED) &&
                  ((own_allowed && own_ev) || (cross_allowed && cross_go));
  assign wr     = !arm && sample_ok && (go || (ph == PH_RUN && pace_ok));
  assign last   = (ptr == AW'(DEPTH - 1));
  assign armed  = (ph == PH_ARMED);
  assign done   = (ph == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      ptr <= '0;
    end else if (arm) begin
      ph  <= en ? PH_ARMED : PH_IDLE;
      ptr <= '0;
    end else begin
      if (go) ph <= PH_RUN;
      if (wr) begin
        ptr <= ptr + 1'b1;
        if (last) ph <= PH_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[ptr] <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ptr == '0 && !done));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> (done && !wr));

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph == PH_RUN) |-> $past(own_ev || cross_go));

endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_pkg::*;
#(
  parameter int POD_W  = 8,
  parameter int N_PODS = 5,
  parameter int T_PODS = 2,
  parameter int DEPTH  = 1024,
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 8,
  localparam int TW    = T_PODS * POD_W,
  localparam int SW    = (N_PODS - T_PODS) * POD_W,
  localparam int RW    = (SW > TW) ? SW : TW,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PODS*POD_W-1:0]   probe,
  input  logic                      ext_clk,
  input  logic                      ext_qual,
  input  logic [N_PODS-1:0]         pod_en,
  input  logic [1:0]                xtrig_mode,
  input  logic                      arm,
  input  logic [DIV_W-1:0]          t_div,
  input  logic [DLY_W-1:0]          s_delay,
  input  logic [TW-1:0]             t_mask,
  input  logic [TW-1:0]             t_match,
  input  logic [SW-1:0]             s_mask,
  input  logic [SW-1:0]             s_match,
  input  logic                      rd_sel,
  input  logic [AW-1:0]             rd_addr,
  output logic [RW-1:0]             rd_data,
  output logic                      t_armed,
  output logic                      t_done,
  output logic                      s_armed,
  output logic                      s_done
);
  xtrig_e        xm;
  logic [TW-1:0] t_keep, t_word, t_rd;
  logic [SW-1:0] s_keep, s_word, s_rd;
  logic          t_en, s_en;
  logic          t_ev, s_ev, t_wr, s_wr;
  logic          t_tick, s_strobe;
  logic          sel_q;

  assign xm = xtrig_e'(xtrig_mode);

  for (genvar p = 0; p < N_PODS; p++) begin : g_pod
    if (p < T_PODS) begin : g_tpod
      assign t_keep[p*POD_W +: POD_W] = {POD_W{pod_en[p]}};
    end else begin : g_spod
      assign s_keep[(p-T_PODS)*POD_W +: POD_W] = {POD_W{pod_en[p]}};
    end
  end

  assign t_word = probe[TW-1:0] & t_keep;
  assign s_word = probe[N_PODS*POD_W-1:TW] & s_keep;
  assign t_en   = |pod_en[T_PODS-1:0];
  assign s_en   = |pod_en[N_PODS-1:T_PODS];

  la_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .restart(arm), .wr(t_wr), .div(t_div), .tick(t_tick)
  );

  la_edge_sync #(.DLY_W(DLY_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_qual(ext_qual),
    .delay(s_delay), .strobe(s_strobe)
  );

  la_machine #(.W(TW), .DEPTH(DEPTH)) u_timing (
    .clk(clk), .rst_n(rst_n), .en(t_en), .arm(arm),
    .sample_ok(1'b1), .pace_ok(t_tick),
    .word(t_word), .mask(t_mask), .value(t_match),
    .own_allowed(own_start_ok(xm, 1'b1)), .cross_allowed(cross_start_ok(xm, 1'b1)),
    .cross_go(s_ev), .own_ev(t_ev), .wr(t_wr),
    .armed(t_armed), .done(t_done), .rd_addr(rd_addr), .rd_data(t_rd)
  );

  la_machine #(.W(SW), .DEPTH(DEPTH)) u_state (
    .clk(clk), .rst_n(rst_n), .en(s_en), .arm(arm),
    .sample_ok(s_strobe), .pace_ok(1'b1),
    .word(s_word), .mask(s_mask), .value(s_match),
    .own_allowed(own_start_ok(xm, 1'b0)), .cross_allowed(cross_start_ok(xm, 1'b0)),
    .cross_go(t_ev), .own_ev(s_ev), .wr(s_wr),
    .armed(s_armed), .done(s_done), .rd_addr(rd_addr), .rd_data(s_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= rd_sel;
  end

  assign rd_data = sel_q ? RW'(s_rd) : RW'(t_rd);

  assert_no_pod_no_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !t_en) |=> !t_armed);

  assert_state_store_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr |-> s_strobe);

  assert_t2s_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xm == XT_T2S && $past(xm) == XT_T2S && $fell(s_armed) && !$past(arm))
      |-> $past(t_ev));

endmodule

// File: tb/test_la_capture_core.sv
`timescale 1ns/1ps
module test_la_capture_core;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] probe = '0;
  logic        ext_clk = 1'b0, ext_qual = 1'b0;
  logic [4:0]  pod_en = 5'b11111;
  logic [1:0]  xtrig_mode = 2'd0;
  logic        arm = 1'b0;
  logic [15:0] t_div = '0;
  logic [7:0]  s_delay = '0;
  logic [15:0] t_mask = 16'hFFFF, t_match = 16'hFFFF;
  logic [23:0] s_mask = '0, s_match = '0;
  logic        rd_sel = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [23:0] rd_data;
  logic        t_armed, t_done, s_armed, s_done;

  int n_run = 0, n_fail = 0;
  logic        rd_req = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  la_capture_core #(.DEPTH(DEPTH)) i_la_capture_core (
    .clk(clk), .rst_n(rst_n), .probe(probe), .ext_clk(ext_clk), .ext_qual(ext_qual),
    .pod_en(pod_en), .xtrig_mode(xtrig_mode), .arm(arm), .t_div(t_div),
    .s_delay(s_delay), .t_mask(t_mask), .t_match(t_match), .s_mask(s_mask),
    .s_match(s_match), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .t_armed(t_armed), .t_done(t_done), .s_armed(s_armed), .s_done(s_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data with the scoreboard
  always @(posedge clk) begin
    if (rd_req) begin
      #2;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: read with empty scoreboard, actual %0h expected none", rd_data);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, rd_data, e);
        end
      end
    end
  end

  // driver: issue a read and push its expected value
  task automatic read_exp(input logic sel, input int addr, input logic [23:0] e,
                          input string tag);
    @(negedge clk);
    rd_sel  = sel;
    rd_addr = addr[3:0];
    rd_req  = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic reads_done();
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_ramp(input int n, input int trig_j);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      probe[15:0] = {j[7:0], (j >= trig_j) ? 8'h42 : 8'h00};
    end
  endtask

  task automatic s_pulse(input logic [23:0] d, input logic q);
    @(negedge clk);
    probe[39:16] = d; ext_qual = q; ext_clk = 1'b1;
    idle(5);
    ext_clk = 1'b0;
    idle(5);
  endtask

  task automatic s_pulse_ramp(input logic [23:0] base);
    @(negedge clk);
    probe[39:16] = base; ext_qual = 1'b1; ext_clk = 1'b1;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      probe[39:16] = base + 24'(i);
    end
    @(negedge clk);
    ext_clk = 1'b0;
    idle(4);
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 read data in reset", {8'h0, rd_data}, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R2 reset t_armed", {31'h0, t_armed}, 0);
    chk("R8 reset t_done", {31'h0, t_done}, 0);
    chk("R2 reset s_armed", {31'h0, s_armed}, 0);
    chk("R8 reset s_done", {31'h0, s_done}, 0);

    // R4/R3 timing, divider 0, trigger on low byte 0x42
    t_mask = 16'h00FF; t_match = 16'h0042; s_mask = 24'hFFFFFF; s_match = 24'hFFFFFF;
    do_arm();
    idle(5);
    chk("R2 armed waits", {30'h0, t_armed, t_done}, 2);
    t_ramp(30, 5);
    chk("R8 timing done div0", {30'h0, t_armed, t_done}, 1);
    chk("R2 state still armed", {30'h0, s_armed, s_done}, 2);
    for (int k = 0; k < DEPTH; k++)
      read_exp(1'b0, k, 24'(((5 + k) & 255) * 256 + 'h42), "R4 div0 entry");
    reads_done();

    // R4/R3 divider 2, full 16-bit match
    t_div = 16'd2; t_mask = 16'hFFFF; t_match = 16'h0742; probe[15:0] = '0;
    do_arm();
    t_ramp(60, 5);
    chk("R8 timing done div2", {31'h0, t_done}, 1);
    for (int k = 0; k < DEPTH; k++)
      read_exp(1'b0, k, 24'(((7 + 3 * k) & 255) * 256 + 'h42), "R4 div2 entry");
    reads_done();

    // R1 pod 1 disabled: high byte stored as zero
    t_div = '0; t_mask = 16'h00FF; t_match = 16'h0042; pod_en = 5'b11101; probe[15:0] = '0;
    do_arm();
    t_ramp(30, 5);
    read_exp(1'b0, 0, 24'h000042, "R1 pod1 off entry0");
    read_exp(1'b0, 9, 24'h000042, "R1 pod1 off entry9");
    reads_done();

    // R1 no timing pods: timing does not arm
    pod_en = 5'b11100;
    do_arm();
    idle(2);
    chk("R1 no pod no arm", {30'h0, t_armed, s_armed}, 1);
    pod_en = 5'b11111;

    // R3/R5/R6 state capture with qualifier, trigger on D2
    t_mask = 16'hFFFF; t_match = 16'hFFFF; probe[15:0] = '0;
    s_mask = 24'hFFFFFF; s_match = 24'h100002;
    do_arm();
    s_pulse(24'h100002, 1'b0);
    chk("R6 unqualified edge ignored", {30'h0, s_armed, s_done}, 2);
    for (int i = 0; i < 20; i++) s_pulse(24'h100000 + 24'(i), 1'b1);
    chk("R8 state done", {30'h0, s_armed, s_done}, 1);
    for (int k = 0; k < DEPTH; k++)
      read_exp(1'b1, k, 24'h100002 + 24'(k), "R5 state entry");
    reads_done();

    // R7 delay 4, pod 3 disabled (state bits 15:8)
    s_delay = 8'd4; s_mask = '0; pod_en = 5'b10111;
    do_arm();
    for (int p = 0; p < DEPTH; p++) s_pulse_ramp(24'h55AA00 + 24'(p * 16));
    chk("R8 state done delayed", {31'h0, s_done}, 1);
    for (int p = 0; p < DEPTH; p++)
      read_exp(1'b1, p, 24'h550000 + 24'(p * 16 + 6), "R7 delayed sample");
    reads_done();
    s_delay = '0; pod_en = 5'b11111;

    // R9 mode 2: timing starts state, state own match ignored
    xtrig_mode = 2'd2; t_mask = 16'hFFFF; t_match = 16'h0742; probe[15:0] = '0;
    s_mask = 24'hFFFFFF; s_match = 24'h123456;
    do_arm();
    s_pulse(24'h123456, 1'b1);
    chk("R9 T2S own match ignored", {31'h0, s_armed}, 1);
    t_ramp(30, 5);
    chk("R9 T2S state started", {30'h0, s_armed, s_done}, 0);
    for (int i = 0; i < DEPTH; i++) s_pulse(24'h200000 + 24'(i), 1'b1);
    chk("R9 T2S state filled", {31'h0, s_done}, 1);
    read_exp(1'b1, 0, 24'h200000, "R9 T2S first sample");
    read_exp(1'b1, 15, 24'h20000F, "R9 T2S last sample");
    reads_done();

    // R9 mode 1: state trigger starts both
    xtrig_mode = 2'd1; t_mask = 16'hFFFF; t_match = 16'hFFFF; probe[15:0] = 16'h0000;
    s_mask = '0;
    do_arm();
    idle(5);
    chk("R9 shared timing waits", {31'h0, t_armed}, 1);
    s_pulse(24'h300000, 1'b1);
    idle(20);
    chk("R9 shared timing filled", {30'h0, t_armed, t_done}, 1);
    read_exp(1'b1, 0, 24'h300000, "R9 shared state entry0");
    reads_done();

    // R9 mode 3: state starts timing, timing own match ignored
    xtrig_mode = 2'd3; t_mask = 16'h0000; s_mask = 24'hFFFFFF; s_match = 24'h400000;
    do_arm();
    idle(5);
    chk("R9 S2T own match ignored", {31'h0, t_armed}, 1);
    s_pulse(24'h400001, 1'b1);
    chk("R9 S2T no state hit", {30'h0, t_armed, s_armed}, 3);
    s_pulse(24'h400000, 1'b1);
    chk("R9 S2T timing started", {31'h0, t_armed}, 0);
    idle(20);
    chk("R8 S2T timing done", {31'h0, t_done}, 1);

    // R2 re-arm clears done
    do_arm();
    idle(1);
    chk("R2 rearm clears done", {28'h0, t_armed, t_done, s_armed, s_done}, 4'b1010);

    idle(5);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule